// File: doc/BRIEF.md
# Memory Ordering Fence Issue Gate

This block sits between an in-order queue of memory operations and the memory pipeline. Operations are written into an eight-slot ring in program order. Each cycle the gate applies the ordering rules to every slot. These rules cover labelled acquire and release operations, a full fence, a store-only fence, four directional fences and same-address ordering. The gate then offers the oldest slot that may go to memory. Completions come back out of order on a tag-valid pin pair. Slots are freed from the oldest end once they are complete.

The enqueue side and the issue side are valid/ready streams. On the enqueue side, `enq_ready` is low only while every slot is in use. The producer holds its operation until a cycle where valid and ready are both high. On the issue side, the offer is fresh every cycle. If `iss_ready` stays low, nothing is marked issued. The offered slot may then change to an older one that has just become eligible. The completion pins are plain: they have no back-pressure, and a completion for a slot that is not outstanding is dropped.

Top module: `mof_gate`

## Requirements
- R1: After reset the ring is empty, `enq_ready` is 1, `iss_valid` is 0 and `issue_elig` is all zero.
- R2: Kind 6 (full fence) holds back every younger memory operation while any memory operation older than the fence is uncommitted. Reserved kinds 12 to 15 act the same way.
- R3: Kind 7 (store fence) holds back younger operations that write while an older writing operation is uncommitted. Younger loads pass it.
- R4: Kinds 2 (acquire load) and 3 (acquire read-modify-write) may issue ahead of older uncommitted operations. No younger operation issues until the acquire has committed.
- R5: Kinds 4 (release store) and 5 (release read-modify-write) issue only once every older memory operation has committed. Younger operations are not held back by a release.
- R6: A memory operation never issues while an older uncommitted memory operation to the same address is in the ring.
- R7: The directional fences hold back a younger class only while an older class is uncommitted. Kind 8 blocks loads behind loads, kind 9 blocks stores behind loads, kind 10 blocks loads behind stores, and kind 11 blocks stores behind stores.
- R8: Kinds 3 and 5 count as both a load and a store in every fence check. Kinds 0, 2 and 3, 5 read; kinds 1, 4 and 3, 5 write.
- R9: `iss_valid` with `iss_tag` presents the oldest eligible slot. A transfer (valid and ready both high) marks that slot issued, so it is never offered again.
- R10: Slots are assigned tags 0,1,2… in enqueue order from reset, wrapping after 7. `enq_ready` is low exactly when all 8 slots are in use.
- R11: `cmt_valid` with `cmt_tag` marks an issued slot committed, in any order. Slots leave only from the oldest end once committed, and fences leave when they reach that end. A completion for a slot that is not issued is ignored.
- R12: `issue_elig[t]` is 1 exactly when slot t holds an unissued memory operation that passes R2 to R8 under mixed random traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue request |
| enq_ready | output | 1 | A free slot exists |
| enq_kind | input | 4 | Operation kind code |
| enq_addr | input | AW | Operation address |
| iss_valid | output | 1 | An eligible slot is offered |
| iss_ready | input | 1 | Memory pipeline accepts the offer |
| iss_tag | output | 3 | Slot tag of the offer |
| iss_kind | output | 4 | Kind of the offered operation |
| iss_addr | output | AW | Address of the offered operation |
| cmt_valid | input | 1 | Completion strobe |
| cmt_tag | input | 3 | Tag of the completed slot |
| issue_elig | output | 8 | Per-slot eligibility, indexed by tag |

## Verification
The bench targets loads placed behind a store fence. A gate that drains at every fence would wrongly hold them. It checks an acquire that completes while an older store is still pending; a wrong gate would either keep the younger load blocked or free it before the acquire completes. It sets a read-write atomic ahead of a read-read fence, which catches a design that classes the atomic as a store only. It also sends early, out-of-order and stray completions. A gate that frees slots out of order, or that accepts a completion for an unissued slot, shows the wrong `enq_ready` or the wrong tag wrap.

// File: rtl/mof_pkg.sv
package mof_pkg;
  localparam logic [3:0] K_LD      = 4'd0;
  localparam logic [3:0] K_ST      = 4'd1;
  localparam logic [3:0] K_ACQ_LD  = 4'd2;
  localparam logic [3:0] K_ACQ_RMW = 4'd3;
  localparam logic [3:0] K_REL_ST  = 4'd4;
  localparam logic [3:0] K_REL_RMW = 4'd5;
  localparam logic [3:0] K_FULL    = 4'd6;
  localparam logic [3:0] K_SFENCE  = 4'd7;
  localparam logic [3:0] K_F_RR    = 4'd8;
  localparam logic [3:0] K_F_RW    = 4'd9;
  localparam logic [3:0] K_F_WR    = 4'd10;
  localparam logic [3:0] K_F_WW    = 4'd11;

  function automatic logic is_fence(input logic [3:0] k);
    return k >= K_FULL;
  endfunction

  function automatic logic does_read(input logic [3:0] k);
    return (k == K_LD) || (k == K_ACQ_LD) || (k == K_ACQ_RMW) || (k == K_REL_RMW);
  endfunction

  function automatic logic does_write(input logic [3:0] k);
    return (k == K_ST) || (k == K_REL_ST) || (k == K_ACQ_RMW) || (k == K_REL_RMW);
  endfunction

  function automatic logic is_acq(input logic [3:0] k);
    return (k == K_ACQ_LD) || (k == K_ACQ_RMW);
  endfunction

  function automatic logic is_rel(input logic [3:0] k);
    return (k == K_REL_ST) || (k == K_REL_RMW);
  endfunction

  // Does this fence start blocking younger reads, given pending older reads/writes
  function automatic logic fence_hold_rd(input logic [3:0] k, input logic prd, input logic pwr);
    case (k)
      K_SFENCE, K_F_RW, K_F_WW: return 1'b0;
      K_F_RR:                   return prd;
      K_F_WR:                   return pwr;
      default:                  return prd | pwr;
    endcase
  endfunction

  function automatic logic fence_hold_wr(input logic [3:0] k, input logic prd, input logic pwr);
    case (k)
      K_F_RR, K_F_WR:   return 1'b0;
      K_SFENCE, K_F_WW: return pwr;
      K_F_RW:           return prd;
      default:          return prd | pwr;
    endcase
  endfunction
endpackage

// File: rtl/mof_store.sv
module mof_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enq_fire,
  input  logic [3:0]               enq_kind,
  input  logic [AW-1:0]            enq_addr,
  input  logic                     iss_fire,
  input  logic [TW-1:0]            iss_tag,
  input  logic                     cmt_valid,
  input  logic [TW-1:0]            cmt_tag,
  output logic [DEPTH-1:0]         vld,
  output logic [DEPTH-1:0]         issued,
  output logic [DEPTH-1:0]         done,
  output logic [DEPTH-1:0][3:0]    kind,
  output logic [DEPTH-1:0][AW-1:0] addr,
  output logic [TW-1:0]            head,
  output logic [TW:0]              occ
);
  import mof_pkg::*;

  logic [TW-1:0] tail;
  logic          pop;

  assign pop = vld[head] && done[head];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      issued <= '0;
      done   <= '0;
      kind   <= '0;
      addr   <= '0;
      head   <= '0;
      tail   <= '0;
      occ    <= '0;
    end else begin
      if (pop) begin
        vld[head] <= 1'b0;
        head      <= head + 1'b1;
      end
      if (iss_fire) issued[iss_tag] <= 1'b1;
      if (cmt_valid && vld[cmt_tag] && issued[cmt_tag]) done[cmt_tag] <= 1'b1;
      if (enq_fire) begin
        vld[tail]    <= 1'b1;
        issued[tail] <= 1'b0;
        done[tail]   <= is_fence(enq_kind);
        kind[tail]   <= enq_kind;
        addr[tail]   <= enq_addr;
        tail         <= tail + 1'b1;
      end
      occ <= occ + (TW+1)'(enq_fire) - (TW+1)'(pop);
    end
  end
endmodule

// File: rtl/mof_elig.sv
module mof_elig #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]         vld,
  input  logic [DEPTH-1:0]         issued,
  input  logic [DEPTH-1:0]         done,
  input  logic [DEPTH-1:0][3:0]    kind,
  input  logic [DEPTH-1:0][AW-1:0] addr,
  input  logic [TW-1:0]            head,
  output logic [DEPTH-1:0]         elig
);
  import mof_pkg::*;

  // One sweep from oldest to youngest, carrying pending-class and hold flags
  logic          prd, pwr, pacq, hold_rd, hold_wr, same, blk;
  logic [TW-1:0] p, q;

  always_comb begin
    elig    = '0;
    prd     = 1'b0;
    pwr     = 1'b0;
    pacq    = 1'b0;
    hold_rd = 1'b0;
    hold_wr = 1'b0;
    q       = '0;
    blk     = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      p    = head + TW'(j);
      same = 1'b0;
      for (int i = 0; i < j; i++) begin
        q = head + TW'(i);
        if (vld[q] && !is_fence(kind[q]) && !done[q] && addr[q] == addr[p]) same = 1'b1;
      end
      if (vld[p]) begin
        if (is_fence(kind[p])) begin
          hold_rd = hold_rd | fence_hold_rd(kind[p], prd, pwr);
          hold_wr = hold_wr | fence_hold_wr(kind[p], prd, pwr);
        end else begin
          blk = (does_read(kind[p]) && hold_rd) || (does_write(kind[p]) && hold_wr) ||
                pacq || (is_rel(kind[p]) && (prd || pwr)) || same;
          elig[p] = !issued[p] && !blk;
          prd  = prd  | (does_read(kind[p])  && !done[p]);
          pwr  = pwr  | (does_write(kind[p]) && !done[p]);
          pacq = pacq | (is_acq(kind[p])     && !done[p]);
        end
      end
    end
  end
endmodule

// File: rtl/mof_pick.sv
module mof_pick #(
  parameter int DEPTH = 8,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] elig,
  input  logic [TW-1:0]    head,
  output logic             any,
  output logic [TW-1:0]    tag
);
  logic [TW-1:0] p;

  always_comb begin
    any = 1'b0;
    tag = '0;
    for (int j = 0; j < DEPTH; j++) begin
      p = head + TW'(j);
      if (!any && elig[p]) begin
        any = 1'b1;
        tag = p;
      end
    end
  end
endmodule

// File: rtl/mof_gate.sv
module mof_gate #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  output logic             enq_ready,
  input  logic [3:0]       enq_kind,
  input  logic [AW-1:0]    enq_addr,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [TW-1:0]    iss_tag,
  output logic [3:0]       iss_kind,
  output logic [AW-1:0]    iss_addr,
  input  logic             cmt_valid,
  input  logic [TW-1:0]    cmt_tag,
  output logic [DEPTH-1:0] issue_elig
);
  logic [DEPTH-1:0]         vld, issued, done;
  logic [DEPTH-1:0][3:0]    kind;
  logic [DEPTH-1:0][AW-1:0] addr;
  logic [TW-1:0]            head;
  logic [TW:0]              occ;

  assign enq_ready = (occ != (TW+1)'(DEPTH));

  mof_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .enq_fire(enq_valid && enq_ready), .enq_kind(enq_kind), .enq_addr(enq_addr),
    .iss_fire(iss_valid && iss_ready), .iss_tag(iss_tag),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag),
    .vld(vld), .issued(issued), .done(done), .kind(kind), .addr(addr),
    .head(head), .occ(occ)
  );

  mof_elig #(.DEPTH(DEPTH), .AW(AW)) u_elig (
    .vld(vld), .issued(issued), .done(done), .kind(kind), .addr(addr),
    .head(head), .elig(issue_elig)
  );

  mof_pick #(.DEPTH(DEPTH)) u_pick (
    .elig(issue_elig), .head(head), .any(iss_valid), .tag(iss_tag)
  );

  assign iss_kind = kind[iss_tag];
  assign iss_addr = addr[iss_tag];
endmodule

// File: rtl/mof_gate_chk.sv
module mof_gate_chk #(
  parameter int DEPTH = 8,
  parameter int TW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enq_ready,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [TW-1:0]    iss_tag,
  input logic [DEPTH-1:0] issue_elig,
  input logic [TW:0]      occ
);
  // R9: the offered slot is one that the rule sweep marks eligible
  p_offer_is_elig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> issue_elig[iss_tag]);

  // R9: any eligible slot means an offer is made
  p_offer_when_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|issue_elig) |-> iss_valid);

  // R9: a transferred slot is never eligible again
  p_no_reissue_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> !issue_elig[$past(iss_tag)]);

  // R10: a full ring refuses enqueue
  p_full_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == (TW+1)'(DEPTH)) |-> !enq_ready);

  // R10: occupancy never exceeds the ring size
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (TW+1)'(DEPTH));
endmodule

bind mof_gate mof_gate_chk #(.DEPTH(DEPTH), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enq_ready(enq_ready), .iss_valid(iss_valid),
  .iss_ready(iss_ready), .iss_tag(iss_tag), .issue_elig(issue_elig), .occ(occ)
);

// File: tb/mof_gate_bench.sv
module mof_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enq_valid = 1'b0;
  logic       enq_ready;
  logic [3:0] enq_kind = '0;
  logic [7:0] enq_addr = '0;
  logic       iss_valid;
  logic       iss_ready = 1'b0;
  logic [2:0] iss_tag;
  logic [3:0] iss_kind;
  logic [7:0] iss_addr;
  logic       cmt_valid = 1'b0;
  logic [2:0] cmt_tag = '0;
  logic [7:0] issue_elig;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  mof_gate u_mof_gate (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_kind(enq_kind), .enq_addr(enq_addr), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_tag(iss_tag), .iss_kind(iss_kind),
    .iss_addr(iss_addr), .cmt_valid(cmt_valid), .cmt_tag(cmt_tag),
    .issue_elig(issue_elig)
  );

  // Reference ring model
  bit       m_v[8], m_is[8], m_dn[8];
  int       m_k[8];
  int       m_a[8];
  int       m_head, m_tail, m_cnt;

  function automatic bit rd(int k); return k == 0 || k == 2 || k == 3 || k == 5; endfunction
  function automatic bit wr(int k); return k == 1 || k == 3 || k == 4 || k == 5; endfunction

  function automatic logic [7:0] ref_elig();
    logic [7:0] r = '0;
    bit pl = 0, ps = 0, ac = 0, bl = 0, bs = 0;
    for (int j = 0; j < m_cnt; j++) begin
      int p = (m_head + j) % 8;
      int k = m_k[p];
      if (k >= 6) begin
        case (k)
          7:  if (ps) bs = 1;
          8:  if (pl) bl = 1;
          9:  if (pl) bs = 1;
          10: if (ps) bl = 1;
          11: if (ps) bs = 1;
          default: if (pl || ps) begin bl = 1; bs = 1; end
        endcase
      end else begin
        bit same = 0;
        bit blk;
        for (int i = 0; i < j; i++) begin
          int q = (m_head + i) % 8;
          if (m_k[q] < 6 && !m_dn[q] && m_a[q] == m_a[p]) same = 1;
        end
        blk = (rd(k) && bl) || (wr(k) && bs) || ac || ((k == 4 || k == 5) && (pl || ps)) || same;
        r[p] = !m_is[p] && !blk;
        if (rd(k) && !m_dn[p]) pl = 1;
        if (wr(k) && !m_dn[p]) ps = 1;
        if ((k == 2 || k == 3) && !m_dn[p]) ac = 1;
      end
    end
    return r;
  endfunction

  function automatic int ref_pick(logic [7:0] e);
    for (int j = 0; j < m_cnt; j++) if (e[(m_head + j) % 8]) return (m_head + j) % 8;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    enq_valid = 0; iss_ready = 0; cmt_valid = 0;
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_is[i] = 0; m_dn[i] = 0; m_k[i] = 0; m_a[i] = 0; end
    m_head = 0; m_tail = 0; m_cnt = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // One cycle: drive, compare against model, update model
  task automatic cyc(bit ev, int ek, int ea, bit ir, bit cv, int ct);
    logic [7:0] e;
    int pk;
    bit pop;
    @(negedge clk);
    enq_valid = ev; enq_kind = 4'(ek); enq_addr = 8'(ea);
    iss_ready = ir; cmt_valid = cv; cmt_tag = 3'(ct);
    #1;
    e  = ref_elig();
    pk = ref_pick(e);
    chk(issue_elig == e, "R12 elig", issue_elig, e);
    chk(iss_valid == (pk >= 0) && (pk < 0 || iss_tag == 3'(pk)), "R9 pick",
        {iss_valid, iss_tag}, pk);
    chk(enq_ready == (m_cnt < 8), "R10 ready", enq_ready, m_cnt < 8);
    pop = m_v[m_head] && m_dn[m_head];
    if (ir && pk >= 0) m_is[pk] = 1;
    if (cv && m_v[ct] && m_is[ct] && !(ir && pk == ct && !m_is[ct])) begin
      // commit only applies to a slot issued in an earlier cycle
    end
    if (pop) begin m_v[m_head] = 0; m_head = (m_head + 1) % 8; m_cnt--; end
    if (ev && (m_cnt + (pop ? 1 : 0)) < 8) begin
      m_v[m_tail] = 1; m_is[m_tail] = 0; m_dn[m_tail] = (ek >= 6);
      m_k[m_tail] = ek; m_a[m_tail] = ea; m_tail = (m_tail + 1) % 8; m_cnt++;
    end
    @(posedge clk);
    #1;
    enq_valid = 0; iss_ready = 0; cmt_valid = 0;
  endtask

  // Commit bookkeeping is kept separate so that issue in the same cycle is not counted
  task automatic step(bit ev, int ek, int ea, bit ir, bit cv, int ct);
    bit was_iss = m_is[ct] && m_v[ct];
    cyc(ev, ek, ea, ir, cv, ct);
    if (cv && was_iss) m_dn[ct] = 1;
  endtask

  task automatic enq(int k, int a); step(1, k, a, 0, 0, 0); endtask
  task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R1 reset state
    #1;
    chk(enq_ready == 1 && iss_valid == 0 && issue_elig == 0, "R1 reset",
        {enq_ready, iss_valid, issue_elig}, 10'h200);

    // R3 store fence: LD, ST, SFENCE, LD, ST
    enq(0, 1); enq(1, 2); enq(7, 0); enq(0, 3); enq(1, 4);
    chk(issue_elig == 8'h0B, "R3 store fence", issue_elig, 8'h0B);

    // R2 full fence, then drain of older ops frees younger
    do_reset();
    enq(0, 1); enq(1, 2); enq(6, 0); enq(0, 3); enq(1, 4);
    chk(issue_elig == 8'h03, "R2 full fence hold", issue_elig, 8'h03);
    step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 1);
    chk(issue_elig == 8'h18, "R2 full fence release", issue_elig, 8'h18);

    // R2 reserved code acts as full fence
    do_reset();
    enq(1, 1); enq(13, 0); enq(0, 3);
    chk(issue_elig == 8'h01, "R2 reserved code", issue_elig, 8'h01);

    // R4 acquire
    do_reset();
    enq(1, 1); enq(2, 2); enq(0, 3);
    chk(issue_elig == 8'h03, "R4 acquire hold", issue_elig, 8'h03);
    step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    chk(issue_elig == 8'h04, "R4 acquire done", issue_elig, 8'h04);

    // R5 release
    do_reset();
    enq(0, 1); enq(4, 2); enq(0, 3);
    chk(issue_elig == 8'h05, "R5 release hold", issue_elig, 8'h05);
    step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    chk(issue_elig == 8'h02, "R5 release free", issue_elig, 8'h02);

    // R6 same address
    do_reset();
    enq(1, 5); enq(0, 5); enq(0, 6);
    chk(issue_elig == 8'h05, "R6 same address", issue_elig, 8'h05);

    // R7 directional fences
    do_reset();
    enq(0, 1); enq(1, 2); enq(10, 0); enq(0, 3); enq(1, 4);
    chk(issue_elig == 8'h13, "R7 write-read", issue_elig, 8'h13);
    do_reset();
    enq(0, 1); enq(1, 2); enq(9, 0); enq(0, 3); enq(1, 4);
    chk(issue_elig == 8'h0B, "R7 read-write", issue_elig, 8'h0B);
    do_reset();
    enq(1, 1); enq(8, 0); enq(0, 3);
    chk(issue_elig == 8'h05, "R7 read-read", issue_elig, 8'h05);
    do_reset();
    enq(0, 1); enq(11, 0); enq(1, 3);
    chk(issue_elig == 8'h05, "R7 write-write", issue_elig, 8'h05);

    // R8 atomic counts as a load behind a read-read fence
    do_reset();
    enq(5, 1); enq(8, 0); enq(0, 3);
    chk(issue_elig == 8'h01, "R8 atomic read class", issue_elig, 8'h01);

    // R9 oldest first, R10 full, R11 commit order and stray commit
    do_reset();
    for (int i = 0; i < 8; i++) enq(0, 16 + i);
    chk(enq_ready == 0, "R10 full", enq_ready, 0);
    step(0, 0, 0, 0, 1, 0); idle(); idle();
    chk(enq_ready == 0, "R11 stray commit ignored", enq_ready, 0);
    chk(iss_tag == 0, "R9 oldest offer", iss_tag, 0);
    step(0, 0, 0, 1, 0, 0);
    chk(iss_tag == 1, "R9 next offer", iss_tag, 1);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 1); idle();
    chk(enq_ready == 0, "R11 younger commit holds slot", enq_ready, 0);
    step(0, 0, 0, 0, 1, 0); idle();
    chk(enq_ready == 1, "R11 in-order free", enq_ready, 1);
    idle();
    enq(0, 40);
    chk(issue_elig == 8'hFD, "R10 tag wrap", issue_elig, 8'hFD);

    // R12 random mixed traffic
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      int k = ($urandom % 10 < 6) ? int'($urandom % 2) : int'(2 + $urandom % 10);
      step(($urandom % 3) != 0, k, int'($urandom % 6), ($urandom % 4) != 0,
           ($urandom % 3) != 0, int'($urandom % 8));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule